// File: doc/BRIEF.md
# Glitch-Free Card Clock Mode Switcher

This block produces the clock driven to a smart card. A fast system clock samples every input, an external reference clock and a free-running internal oscillator among them. It runs the card clock in one of four modes: straight from the internal oscillator, from the external clock divided by a power of two, held low, or held high. A host writes an 8-bit settings byte to select the mode and the divide ratio. The block accepts only a fixed set of mode changes. It protects the ratio field when a non-divide mode is written. It moves the output from one source to another only at an instant where the two agree, so the card never sees a shortened high or low phase.

The settings write is a valid/ready port. A byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` never depends on `wr_valid`. It drops while a mode change is still waiting for its switching instant, and also while shutdown is asserted. A writer holds `wr_valid` and `wr_data` steady until the byte is taken. A start pulse for card activation forces the divided clock while internal mode is selected, and a done pulse releases it. A shutdown input returns everything to a safe forced-low state. A status flag shows when the internal oscillator really drives the output.

Top module: `card_clk_switch`

## Requirements
- R1: The mode decodes from `cfg_q[7:5]`: bit 7 selects the internal oscillator, otherwise bit 6 selects forced low, otherwise bit 5 selects forced high, and all three clear selects the divided clock. `card_clk` follows the selected source with one register of delay.
- R2: The only mode changes carried out are internal→divided, divided→internal, divided→low, divided→high, low→divided and high→divided. Any other requested change leaves `cfg_q` and `card_clk` as they were.
- R3: When an accepted write has any of bits [7:5] set, `cfg_q[4:2]` keeps its old value. `cfg_q[1:0]` always reads zero.
- R4: With ratio code c in `cfg_q[4:2]`, the divided clock has a period of 2^(c+1) external clock periods. A new code takes effect only at a rising edge of the divided clock.
- R5: A change between divided mode and a static level, in either direction, happens only in a cycle where the divided clock already equals that static level.
- R6: A change from divided to internal happens only when the rising edges of both clocks are seen no more than `COINC_WIN` system cycles apart, with both clocks high. Until then, the divided clock keeps driving the output.
- R7: If internal mode is selected when an activation start pulse arrives, the output runs from the divided clock until the activation done pulse, and then returns to the internal oscillator.
- R8: `clk_sw` is high exactly while the internal oscillator drives `card_clk`. It falls when the output leaves internal mode.
- R9: A write that requests a forbidden change is dropped and sets `mode_err`. `mode_err` stays set until the next accepted write that is permitted.
- R10: Shutdown resets the block to forced-low mode with ratio code 0 (`cfg_q` = 0x40). It clears `mode_err` and `clk_sw`, drives `card_clk` low, and cancels any switch still pending.
- R11: `wr_ready` is low while a mode change is pending or shutdown is asserted. While it is low, a held write has no effect on `cfg_q`.
- R12: A change from internal to divided happens only in a cycle where both the oscillator and the divided clock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn | input | 1 | Shutdown request, synchronized inside |
| wr_valid | input | 1 | Settings byte offered |
| wr_ready | output | 1 | Settings byte can be taken |
| wr_data | input | 8 | Settings byte: [7:5] mode select, [4:2] ratio code |
| ext_clk | input | 1 | External reference clock |
| int_osc | input | 1 | Internal oscillator clock |
| act_start | input | 1 | Activation start pulse |
| act_done | input | 1 | Activation done pulse |
| card_clk | output | 1 | Clock driven to the card |
| clk_sw | output | 1 | Internal oscillator is on the output |
| mode_err | output | 1 | Sticky flag: a forbidden mode request was dropped |
| cfg_q | output | 8 | Current settings byte |

## Verification
The assertions check the switching instants on every cycle. A change between divided mode and a static level must occur at a matching level, a hand-over in either direction with the oscillator must occur with both clocks at the same level, and a static mode can never jump straight to the oscillator. They also check the forced output levels, the shutdown state, and that a blocked write leaves the settings alone. Only the bench scenarios can show the longer-range behaviour: the measured divider periods, a ratio change landing on an output rising edge, an indefinite wait while the oscillator is stopped, the activation override and its release, and the ratio lock across writes.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [1:0] {
    M_INT = 2'd0,
    M_DIV = 2'd1,
    M_LO  = 2'd2,
    M_HI  = 2'd3
  } cc_mode_e;

  // Select bits [7:5]: internal has priority, then low, then high.
  function automatic cc_mode_e cc_decode(input logic [2:0] sel);
    if (sel[2])      return M_INT;
    else if (sel[1]) return M_LO;
    else if (sel[0]) return M_HI;
    else             return M_DIV;
  endfunction

  // Every permitted edge of the mode graph touches divided mode.
  function automatic logic cc_allowed(input cc_mode_e from, input cc_mode_e to);
    return (from == to) || (from == M_DIV) || (to == M_DIV);
  endfunction

endpackage

// File: rtl/cc_sync.sv
module cc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cc_divider.sv
module cc_divider #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              ext_rise,
  input  logic [CODE_W-1:0] code_in,
  output logic              div_q
);
  localparam int CNT_W = 1 << CODE_W;

  logic [CODE_W-1:0] act_code;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  half_m1;

  // Each half period spans 2^code external rising edges.
  assign half_m1 = (CNT_W'(1) << act_code) - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      div_q    <= 1'b0;
      act_code <= '0;
    end else if (clr) begin
      cnt      <= '0;
      div_q    <= 1'b0;
      act_code <= '0;
    end else if (ext_rise) begin
      if (cnt == half_m1) begin
        cnt   <= '0;
        div_q <= ~div_q;
        // A new ratio is adopted only as the output rises.
        if (!div_q) act_code <= code_in;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cc_mode_ctrl.sv
module cc_mode_ctrl
  import cc_pkg::*;
#(
  parameter int COINC_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_s,
  input  logic       wr_valid,
  input  logic [7:2] wr_bits,
  output logic       wr_ready,
  input  logic       int_s,
  input  logic       int_rise,
  input  logic       start_rise,
  input  logic       done_rise,
  input  logic       div_q,
  output logic [7:0] cfg_q,
  output logic [2:0] ratio,
  output cc_mode_e   cur_mode,
  output logic       mode_err,
  output logic       card_clk,
  output logic       clk_sw
);
  localparam int AGE_W = $clog2(COINC_WIN + 1);
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(COINC_WIN);

  cc_mode_e         cur_q, tgt, cfg_mode, req;
  logic [7:0]       cfg_r;
  logic             in_act, err_r, cclk_r, sw_r, div_prev;
  logic [AGE_W-1:0] age_div, age_int;
  logic             pending, fire, div_up, coinc, sw_ok;

  assign cfg_mode = cc_decode(cfg_r[7:5]);
  assign req      = cc_decode(wr_bits[7:5]);
  assign tgt      = (cfg_mode == M_INT && in_act) ? M_DIV : cfg_mode;
  assign pending  = (cur_q != tgt);
  assign wr_ready = !pending && !shdn_s;
  assign fire     = wr_valid && wr_ready;
  assign div_up   = div_q && !div_prev;
  assign coinc    = (int_rise && div_q && (div_up || age_div < AGE_SAT)) ||
                    (div_up && int_s && age_int < AGE_SAT);

  always_comb begin
    sw_ok = 1'b0;
    unique case (cur_q)
      M_DIV: begin
        case (tgt)
          M_LO:    sw_ok = !div_q;
          M_HI:    sw_ok = div_q;
          M_INT:   sw_ok = coinc;
          default: sw_ok = 1'b0;
        endcase
      end
      M_LO:  sw_ok = (tgt == M_DIV) && !div_q;
      M_HI:  sw_ok = (tgt == M_DIV) && div_q;
      M_INT: sw_ok = (tgt == M_DIV) && !div_q && !int_s;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r    <= 8'h40;
      cur_q    <= M_LO;
      in_act   <= 1'b0;
      err_r    <= 1'b0;
      cclk_r   <= 1'b0;
      sw_r     <= 1'b0;
      div_prev <= 1'b0;
      age_div  <= AGE_SAT;
      age_int  <= AGE_SAT;
    end else if (shdn_s) begin
      cfg_r    <= 8'h40;
      cur_q    <= M_LO;
      in_act   <= 1'b0;
      err_r    <= 1'b0;
      cclk_r   <= 1'b0;
      sw_r     <= 1'b0;
      div_prev <= 1'b0;
      age_div  <= AGE_SAT;
      age_int  <= AGE_SAT;
    end else begin
      div_prev <= div_q;
      if (div_up)                 age_div <= '0;
      else if (age_div != AGE_SAT) age_div <= age_div + AGE_W'(1);
      if (int_rise)               age_int <= '0;
      else if (age_int != AGE_SAT) age_int <= age_int + AGE_W'(1);

      if (start_rise)     in_act <= 1'b1;
      else if (done_rise) in_act <= 1'b0;

      if (fire) begin
        if (cc_allowed(cfg_mode, req)) begin
          err_r      <= 1'b0;
          cfg_r[7:5] <= wr_bits[7:5];
          if (wr_bits[7:5] == 3'b000) cfg_r[4:2] <= wr_bits[4:2];
        end else begin
          err_r <= 1'b1;
        end
      end

      if (pending && sw_ok) cur_q <= tgt;

      unique case (cur_q)
        M_INT: cclk_r <= int_s;
        M_DIV: cclk_r <= div_q;
        M_LO:  cclk_r <= 1'b0;
        M_HI:  cclk_r <= 1'b1;
      endcase
      sw_r <= (cur_q == M_INT);
    end
  end

  assign cfg_q    = {cfg_r[7:2], 2'b00};
  assign ratio    = cfg_r[4:2];
  assign cur_mode = cur_q;
  assign mode_err = err_r;
  assign card_clk = cclk_r;
  assign clk_sw   = sw_r;
endmodule

// File: rtl/card_clk_switch.sv
module card_clk_switch #(
  parameter int SYNC_STAGES = 2,
  parameter int COINC_WIN   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic       ext_clk,
  input  logic       int_osc,
  input  logic       act_start,
  input  logic       act_done,
  output logic       card_clk,
  output logic       clk_sw,
  output logic       mode_err,
  output logic [7:0] cfg_q
);
  localparam int CODE_W = 3;
  localparam int N_IN   = 5;

  logic [N_IN-1:0] lvl;
  logic [3:0]      edge_prev, rise;
  logic            shdn_s, int_s, div_q;
  logic [CODE_W-1:0] ratio;
  cc_pkg::cc_mode_e  cur_mode;
  logic            unused_rsvd;

  assign unused_rsvd = ^wr_data[1:0];

  cc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({shdn, act_done, act_start, int_osc, ext_clk}),
    .q     (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_prev <= '0;
    else        edge_prev <= lvl[3:0];
  end

  assign rise   = lvl[3:0] & ~edge_prev;
  assign shdn_s = lvl[4];
  assign int_s  = lvl[1];

  cc_divider #(.CODE_W(CODE_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (shdn_s),
    .ext_rise (rise[0]),
    .code_in  (ratio),
    .div_q    (div_q)
  );

  cc_mode_ctrl #(.COINC_WIN(COINC_WIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_s     (shdn_s),
    .wr_valid   (wr_valid),
    .wr_bits    (wr_data[7:2]),
    .wr_ready   (wr_ready),
    .int_s      (int_s),
    .int_rise   (rise[1]),
    .start_rise (rise[2]),
    .done_rise  (rise[3]),
    .div_q      (div_q),
    .cfg_q      (cfg_q),
    .ratio      (ratio),
    .cur_mode   (cur_mode),
    .mode_err   (mode_err),
    .card_clk   (card_clk),
    .clk_sw     (clk_sw)
  );
endmodule

// File: rtl/cc_checker.sv
module cc_checker
  import cc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       shdn_s,
  input cc_mode_e   cur_mode,
  input logic       div_q,
  input logic       int_s,
  input logic       card_clk,
  input logic       clk_sw,
  input logic       mode_err,
  input logic [7:0] cfg_q,
  input logic       wr_valid,
  input logic       wr_ready
);
  assert_low_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_LO) |=> !card_clk);

  assert_high_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_HI && !shdn_s) |=> card_clk);

  assert_no_static_to_int_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_INT && $past(cur_mode) != M_INT) |-> ($past(cur_mode) == M_DIV));

  assert_div_to_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_LO && $past(cur_mode) == M_DIV && !$past(shdn_s)) |-> !$past(div_q));

  assert_div_to_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_HI && $past(cur_mode) == M_DIV) |-> $past(div_q));

  assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_INT && $past(cur_mode) == M_DIV) |-> ($past(div_q) && $past(int_s)));

  assert_sw_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw |-> (card_clk == $past(int_s)));

  assert_err_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_err) |-> $past(wr_valid && wr_ready));

  assert_shutdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_s |=> (cfg_q == 8'h40 && !mode_err && !clk_sw && !card_clk));

  assert_blocked_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !shdn_s) |=> $stable(cfg_q));

  assert_int_to_div_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == M_DIV && $past(cur_mode) == M_INT) |-> (!$past(div_q) && !$past(int_s)));
endmodule

bind card_clk_switch cc_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shdn_s   (shdn_s),
  .cur_mode (cur_mode),
  .div_q    (div_q),
  .int_s    (int_s),
  .card_clk (card_clk),
  .clk_sw   (clk_sw),
  .mode_err (mode_err),
  .cfg_q    (cfg_q),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready)
);

// File: tb/test_card_clk_switch.sv
module test_card_clk_switch;
  localparam int WIN = 4;

  logic clk = 1'b0, rst_n = 1'b0, shdn = 1'b0;
  logic ext_clk = 1'b0, int_osc = 1'b0, act_start = 1'b0, act_done = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, card_clk, clk_sw, mode_err;
  logic [7:0] cfg_q;

  int errors = 0, checks = 0, cyc = 0, int_cnt = 0;
  bit int_run = 1'b1, cmp_on = 1'b0;

  always #2 clk = ~clk;

  card_clk_switch #(.SYNC_STAGES(2), .COINC_WIN(WIN)) i_card_clk_switch (
    .clk(clk), .rst_n(rst_n), .shdn(shdn), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .ext_clk(ext_clk), .int_osc(int_osc), .act_start(act_start),
    .act_done(act_done), .card_clk(card_clk), .clk_sw(clk_sw), .mode_err(mode_err),
    .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // modes: 0 internal, 1 divided, 2 low, 3 high
  bit [4:0] ms0, ms1;
  bit [3:0] mprev;
  bit [7:0] m_cfg;
  int m_cnt, m_code, m_cur, m_agd, m_agi;
  bit m_div, m_act, m_err, m_cclk, m_sw, m_dprev;

  function automatic int dec(input bit [2:0] s);
    if (s[2]) return 0;
    if (s[1]) return 2;
    if (s[0]) return 3;
    return 1;
  endfunction

  function automatic int m_tgt();
    int sel = dec(m_cfg[7:5]);
    return (sel == 0 && m_act) ? 1 : sel;
  endfunction

  function automatic bit m_rdy();
    return (m_cur == m_tgt()) && !ms1[4];
  endfunction

  always @(posedge clk) begin : model
    bit [4:0] lvl;
    bit [3:0] rs;
    bit shd, pend, fire, dup, coinc, ok, o_div;
    int tgt, o_cur, from, req;
    if (!rst_n) begin
      ms0 = 0; ms1 = 0; mprev = 0; m_cnt = 0; m_code = 0; m_div = 0;
      m_cfg = 8'h40; m_cur = 2; m_act = 0; m_err = 0; m_cclk = 0; m_sw = 0;
      m_dprev = 0; m_agd = WIN; m_agi = WIN;
    end else begin
      lvl = ms1; rs = lvl[3:0] & ~mprev; shd = lvl[4];
      tgt = m_tgt(); pend = (m_cur != tgt); fire = wr_valid && !pend && !shd;
      dup = m_div && !m_dprev;
      coinc = (rs[1] && m_div && (dup || m_agd < WIN)) || (dup && lvl[1] && m_agi < WIN);
      ok = 0;
      if (m_cur == 1) ok = (tgt == 2) ? !m_div : (tgt == 3) ? m_div : (tgt == 0) ? coinc : 0;
      else if (m_cur == 2) ok = (tgt == 1) && !m_div;
      else if (m_cur == 3) ok = (tgt == 1) && m_div;
      else ok = (tgt == 1) && !m_div && !lvl[1];
      o_div = m_div; o_cur = m_cur;
      if (shd) begin
        m_cnt = 0; m_div = 0; m_code = 0;
      end else if (rs[0]) begin
        if (m_cnt == (1 << m_code) - 1) begin
          m_cnt = 0;
          if (!m_div) m_code = int'(m_cfg[4:2]);
          m_div = !m_div;
        end else m_cnt++;
      end
      if (shd) begin
        m_cfg = 8'h40; m_cur = 2; m_act = 0; m_err = 0; m_cclk = 0; m_sw = 0;
        m_dprev = 0; m_agd = WIN; m_agi = WIN;
      end else begin
        m_dprev = o_div;
        m_agd = dup ? 0 : (m_agd < WIN ? m_agd + 1 : WIN);
        m_agi = rs[1] ? 0 : (m_agi < WIN ? m_agi + 1 : WIN);
        if (rs[2]) m_act = 1; else if (rs[3]) m_act = 0;
        if (fire) begin
          from = dec(m_cfg[7:5]); req = dec(wr_data[7:5]);
          if (from == req || from == 1 || req == 1) begin
            m_err = 0;
            if (wr_data[7:5] != 0) m_cfg = {wr_data[7:5], m_cfg[4:2], 2'b00};
            else m_cfg = {wr_data[7:2], 2'b00};
          end else m_err = 1;
        end
        if (pend && ok) m_cur = tgt;
        m_cclk = (o_cur == 0) ? lvl[1] : (o_cur == 1) ? o_div : (o_cur == 3);
        m_sw = (o_cur == 0);
      end
      ms1 = ms0;
      ms0 = {shdn, act_done, act_start, int_osc, ext_clk};
      mprev = lvl[3:0];
    end
  end

  // ---------------- source clocks, watchdog, per-cycle compare ----------------
  always @(negedge clk) begin
    cyc++;
    if (cyc % 4 == 0) ext_clk = ~ext_clk;
    if (int_run) begin
      int_cnt++;
      if (int_cnt == 3) begin int_cnt = 0; int_osc = ~int_osc; end
    end
    if (cmp_on) begin
      chk("R4", "card_clk vs model", card_clk, m_cclk);
      chk("R8", "clk_sw vs model", clk_sw, m_sw);
      chk("R9", "mode_err vs model", mode_err, m_err);
      chk("R3", "cfg_q vs model", cfg_q, m_cfg);
      chk("R11", "wr_ready vs model", wr_ready, m_rdy());
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_write(input logic [7:0] d);
    bit acc;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    for (int i = 0; i < 5000; i++) begin
      acc = wr_ready;
      @(negedge clk);
      if (acc) break;
    end
    wr_valid = 1'b0;
  endtask

  task automatic wait_ready(input int lim);
    for (int i = 0; i < lim && !wr_ready; i++) @(negedge clk);
  endtask

  task automatic wait_rise();
    bit p = card_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (card_clk && !p) break;
      p = card_clk;
    end
  endtask

  task automatic period(input string req, input int exp);
    int n = 0;
    bit p;
    wait_rise(); wait_rise();
    p = card_clk;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); n++;
      if (card_clk && !p) break;
      p = card_clk;
    end
    chk(req, "card_clk period", n, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; cmp_on = 1'b1;
    repeat (4) @(negedge clk);
    // reset state: forced low, code 0
    chk("R10", "reset cfg_q", cfg_q, 8'h40);
    chk("R10", "reset card_clk", card_clk, 0);
    chk("R11", "reset wr_ready", wr_ready, 1);

    // low -> internal is forbidden
    do_write(8'h80);
    chk("R2", "cfg after low->int", cfg_q, 8'h40);
    chk("R9", "err after forbidden", mode_err, 1);
    do_write(8'h20);
    chk("R2", "cfg after low->high", cfg_q, 8'h40);
    chk("R1", "low output held", card_clk, 0);

    // low -> divided, code 1 (divide by 4 = 32 system cycles)
    do_write(8'h04);
    chk("R9", "err cleared by valid write", mode_err, 0);
    chk("R3", "cfg code 1", cfg_q, 8'h04);
    wait_ready(500);
    period("R4", 32);
    do_write(8'h0C);
    period("R4", 128);

    // divided -> high; ratio field locked
    do_write(8'h20);
    chk("R3", "ratio kept on high write", cfg_q, 8'h2C);
    wait_ready(1000);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      chk("R5", "high level held", card_clk, 1);
      repeat (20) @(negedge clk);
    end
    do_write(8'h5C);
    chk("R2", "high->low dropped", cfg_q, 8'h2C);
    chk("R9", "err on high->low", mode_err, 1);
    do_write(8'h00);
    wait_ready(1000);
    period("R4", 16);

    // divided -> internal with the oscillator stopped: must keep waiting
    int_run = 1'b0;
    do_write(8'h9C);
    chk("R3", "ratio kept on int write", cfg_q, 8'h80);
    repeat (300) @(negedge clk);
    chk("R6", "no switch without alignment", clk_sw, 0);
    chk("R11", "ready low while pending", wr_ready, 0);
    period("R6", 16);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h40;
    repeat (5) @(negedge clk);
    chk("R11", "held write blocked", cfg_q, 8'h80);
    wr_valid = 1'b0;
    int_run = 1'b1;
    wait_ready(2000);
    repeat (3) @(negedge clk);
    chk("R8", "clk_sw after switch", clk_sw, 1);
    period("R1", 6);

    // activation override
    @(negedge clk); act_start = 1'b1;
    repeat (3) @(negedge clk); act_start = 1'b0;
    repeat (3) @(negedge clk);
    wait_ready(2000);
    repeat (3) @(negedge clk);
    chk("R7", "divided during activation", clk_sw, 0);
    period("R7", 16);
    @(negedge clk); act_done = 1'b1;
    repeat (3) @(negedge clk); act_done = 1'b0;
    repeat (3) @(negedge clk);
    wait_ready(2000);
    repeat (3) @(negedge clk);
    chk("R7", "internal after done", clk_sw, 1);

    // forbidden internal -> low, then shutdown
    do_write(8'h40);
    chk("R2", "int->low dropped", cfg_q, 8'h80);
    chk("R9", "err on int->low", mode_err, 1);
    @(negedge clk); shdn = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "ready low in shutdown", wr_ready, 0);
    shdn = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "cfg after shutdown", cfg_q, 8'h40);
    chk("R10", "err after shutdown", mode_err, 0);
    chk("R10", "clk_sw after shutdown", clk_sw, 0);
    chk("R10", "card_clk after shutdown", card_clk, 0);

    // internal -> divided
    do_write(8'h04);
    wait_ready(1000);
    do_write(8'h80);
    chk("R3", "code 1 kept", cfg_q, 8'h84);
    wait_ready(2000);
    repeat (3) @(negedge clk);
    chk("R8", "clk_sw on internal", clk_sw, 1);
    do_write(8'h00);
    wait_ready(2000);
    repeat (3) @(negedge clk);
    chk("R12", "clk_sw cleared after leaving", clk_sw, 0);
    period("R12", 16);

    repeat (10) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule